// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the target side of a two-wire serial byte memory. A bus master drives a serial clock and shares an open-drain data line with it. The block sees that line as a plain data input and controls it through a single pull-low output, so it only ever sinks the line or lets it float. All bus activity is taken through a two-stage synchronizer on a faster system clock. Start and stop conditions, and both clock edges, are then found from the synchronized samples.

A transfer begins with a select byte. Its upper seven bits must equal `1010`, then `0`, then the two strap inputs, and its last bit chooses read (1) or write (0). A write transfer carries a high and a low word address byte, then data bytes. These go into a one-page staging buffer, and the buffer is copied into the byte array only when the stop condition arrives. Copying it opens a busy window of fixed length. During that window the block does not acknowledge any select byte.

A read transfer returns the byte at the internal address pointer and then moves the pointer on. It keeps returning bytes for as long as the master acknowledges them. A random read is a write transfer that carries only the address, followed by a repeated start and a read select. While the write-protect input is high, every byte is still acknowledged, but the array is never changed.

Top module: `eeprom_slave`

## Requirements
- R1: The select byte is acknowledged only when bits 7..1 equal {1010, 0, strap_i[1], strap_i[0]}. On a mismatch the block leaves the data line released in that acknowledge slot. It also gives no acknowledge to any byte that follows until the next start condition.
- R2: The block acknowledges by pulling the line low (sda_low_o = 1) through the ninth clock. It drives an outgoing bit by pulling low for a 0 and releasing for a 1. sda_low_o changes only while the serial clock is low, and it is 0 whenever no transfer is active.
- R3: A byte write is a write select, a high address byte, a low address byte, one data byte and a stop. It leaves that byte at that address, and each of the four bytes is acknowledged.
- R4: In a multi-byte write, the 6-bit offset within the 64-byte page increments after each data byte and wraps from 63 to 0. The page number does not change, and bytes outside the page are untouched.
- R5: Data bytes reach the array only on a stop condition. A start condition that arrives before the stop discards them.
- R6: For WRITE_CYCLES system clocks after a write is committed, a select byte gets no acknowledge. After that window the select byte is acknowledged again.
- R7: While wp_i is high at the stop condition, the array is not changed, and the select, address and data bytes are all still acknowledged.
- R8: A read select with no address first returns the byte at the current pointer. The pointer is one past the last byte read, or one past the last byte written within its page.
- R9: A random read is a write select, two address bytes, a repeated start and a read select. It returns the byte at that address.
- R10: A sequential read returns consecutive bytes while the master acknowledges each one. The address increments across page boundaries and wraps from the last byte of the array to byte 0.
- R11: Word-address bits above the array's index width are ignored, including the top bit of the high address byte.
- R12: After reset the data line is released, no write window is open, and a matching select byte is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus master |
| sda_i | input | 1 | Sampled level of the shared data line |
| sda_low_o | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_i | input | 2 | Hard-wired device address straps |
| wp_i | input | 1 | Write protect, high blocks all array writes |

## Verification
Every bus edge reaches the protocol logic through two synchronizer stages and one edge register. The pull-low output therefore moves three to four system clocks after the serial clock falls. The bench holds each clock phase for eight system clocks and samples the line twelve clocks after each falling edge, in the middle of the high phase, so it reads acknowledge and read bits only on settled values. A commit ends its busy window WRITE_CYCLES clocks after the stop condition. The bench probes a select byte right after the stop, where a no-acknowledge is due. It then waits a fixed margin well past the window before the next access, where an acknowledge is due.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  // fixed upper part of the select byte: 1010 then 0
  localparam logic [4:0] DEV_CODE = 5'b10100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } bus_state_e;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_AH,
    PH_AL,
    PH_WD
  } byte_phase_e;
endpackage

// File: rtl/eeprom_bus_sync.sv
module eeprom_bus_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic rst_n_sync_o,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] rst_pipe_q;
  logic [1:0] scl_pipe_q, sda_pipe_q;
  logic       scl_prev_q, sda_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_sync_o = rst_pipe_q[1];

  always_ff @(posedge clk_i or negedge rst_n_sync_o) begin
    if (!rst_n_sync_o) begin
      scl_pipe_q <= 2'b11;
      sda_pipe_q <= 2'b11;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[0], scl_i};
      sda_pipe_q <= {sda_pipe_q[0], sda_i};
      scl_prev_q <= scl_pipe_q[1];
      sda_prev_q <= sda_pipe_q[1];
    end
  end

  assign scl_s_o    = scl_pipe_q[1];
  assign sda_s_o    = sda_pipe_q[1];
  assign scl_rise_o = scl_s_o && !scl_prev_q;
  assign scl_fall_o = !scl_s_o && scl_prev_q;
  assign start_o    = scl_s_o && scl_prev_q && sda_prev_q && !sda_s_o;
  assign stop_o     = scl_s_o && scl_prev_q && !sda_prev_q && sda_s_o;
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int MEM_AW = 11
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [MEM_AW-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [MEM_AW-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [7:0] cells_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) cells_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = cells_q[raddr_i];
endmodule

// File: rtl/eeprom_pagebuf.sv
module eeprom_pagebuf #(
  parameter int OFS_W        = 6,
  parameter int PG_W         = 5,
  parameter int WRITE_CYCLES = 200
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [OFS_W-1:0]      idx_i,
  input  logic [7:0]            data_i,
  input  logic                  clr_i,
  input  logic                  commit_i,
  input  logic [PG_W-1:0]       page_i,
  output logic                  busy_o,
  output logic                  mem_we_o,
  output logic [PG_W+OFS_W-1:0] mem_waddr_o,
  output logic [7:0]            mem_wdata_o
);
  localparam int NB  = 1 << OFS_W;
  localparam int CYC = (WRITE_CYCLES < NB) ? NB : WRITE_CYCLES;
  localparam int CW  = $clog2(CYC + 1);

  logic [7:0]      data_q [NB];
  logic [NB-1:0]   valid_q, valid_d;
  logic            busy_q, busy_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [PG_W-1:0] page_q, page_d;
  logic [OFS_W-1:0] drain_idx;
  logic            in_drain;

  always_ff @(posedge clk_i) begin
    if (we_i) data_q[idx_i] <= data_i;
  end

  always_comb begin
    valid_d = valid_q;
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    page_d  = page_q;
    if (busy_q) begin
      if (cnt_q == CW'(CYC - 1)) begin
        busy_d  = 1'b0;
        cnt_d   = '0;
        valid_d = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end else begin
      if (commit_i) begin
        busy_d = 1'b1;
        cnt_d  = '0;
        page_d = page_i;
      end else if (clr_i) begin
        valid_d = '0;
      end
      if (we_i) valid_d[idx_i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      page_q  <= '0;
    end else begin
      valid_q <= valid_d;
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      page_q  <= page_d;
    end
  end

  assign in_drain    = busy_q && (cnt_q < CW'(NB));
  assign drain_idx   = cnt_q[OFS_W-1:0];
  assign mem_we_o    = in_drain && valid_q[drain_idx];
  assign mem_waddr_o = {page_q, drain_idx};
  assign mem_wdata_o = data_q[drain_idx];
  assign busy_o      = busy_q;
endmodule

// File: rtl/eeprom_fsm.sv
module eeprom_fsm
  import eeprom_pkg::*;
#(
  parameter int OFS_W  = 6,
  parameter int MEM_AW = 11
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    scl_rise_i,
  input  logic                    scl_fall_i,
  input  logic                    start_i,
  input  logic                    stop_i,
  input  logic                    sda_s_i,
  input  logic [1:0]              strap_i,
  input  logic                    wp_i,
  input  logic                    busy_i,
  input  logic [7:0]              rd_data_i,
  output logic [MEM_AW-1:0]       addr_o,
  output logic                    buf_we_o,
  output logic [OFS_W-1:0]        buf_idx_o,
  output logic [7:0]              buf_data_o,
  output logic                    buf_clr_o,
  output logic                    commit_o,
  output logic [MEM_AW-OFS_W-1:0] commit_page_o,
  output logic                    drive_low_o,
  output logic                    idle_o,
  output logic                    wr_phase_o
);
  localparam int HI_W = MEM_AW - 8;

  bus_state_e  state_q, state_d;
  byte_phase_e phase_q, phase_d;
  logic [3:0]        cnt_q, cnt_d;
  logic              full_q, full_d;
  logic [7:0]        sh_q, sh_d;
  logic [7:0]        tx_q, tx_d;
  logic [MEM_AW-1:0] addr_q, addr_d;
  logic              rw_q, rw_d;
  logic              mack_q, mack_d;
  logic              drive_q, drive_d;
  logic [2:0]        tx_bit;

  assign tx_bit = 3'(4'd7 - cnt_q);

  always_comb begin
    state_d   = state_q;
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    full_d    = full_q;
    sh_d      = sh_q;
    tx_d      = tx_q;
    addr_d    = addr_q;
    rw_d      = rw_q;
    mack_d    = mack_q;
    drive_d   = drive_q;
    buf_we_o  = 1'b0;
    buf_clr_o = 1'b0;
    commit_o  = 1'b0;
    if (start_i) begin
      state_d   = ST_RX;
      phase_d   = PH_DEV;
      cnt_d     = '0;
      full_d    = 1'b0;
      drive_d   = 1'b0;
      buf_clr_o = !busy_i;
    end else if (stop_i) begin
      if (phase_q == PH_WD && !wp_i && !busy_i) commit_o = 1'b1;
      else buf_clr_o = !busy_i;
      state_d = ST_IDLE;
      phase_d = PH_DEV;
      drive_d = 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise_i) begin
            sh_d = {sh_q[6:0], sda_s_i};
            if (cnt_q == 4'd7) begin
              full_d = 1'b1;
              cnt_d  = '0;
            end else begin
              cnt_d = cnt_q + 4'd1;
            end
          end else if (scl_fall_i && full_q) begin
            full_d  = 1'b0;
            state_d = ST_ACK;
            drive_d = 1'b1;
            case (phase_q)
              PH_DEV: begin
                if (sh_q[7:1] != {DEV_CODE, strap_i} || busy_i) begin
                  state_d = ST_IDLE;
                  drive_d = 1'b0;
                end else begin
                  rw_d = sh_q[0];
                end
              end
              PH_AH:   addr_d[MEM_AW-1:8] = sh_q[HI_W-1:0];
              PH_AL:   addr_d[7:0] = sh_q;
              default: begin
                buf_we_o = 1'b1;
                addr_d[OFS_W-1:0] = addr_q[OFS_W-1:0] + OFS_W'(1);
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            drive_d = 1'b0;
            state_d = ST_RX;
            cnt_d   = '0;
            case (phase_q)
              PH_DEV: begin
                if (rw_q) begin
                  state_d = ST_TX;
                  tx_d    = rd_data_i;
                  addr_d  = addr_q + MEM_AW'(1);
                  drive_d = !rd_data_i[7];
                  cnt_d   = 4'd1;
                end else begin
                  phase_d = PH_AH;
                end
              end
              PH_AH:   phase_d = PH_AL;
              PH_AL:   phase_d = PH_WD;
              default: phase_d = PH_WD;
            endcase
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            if (cnt_q == 4'd8) begin
              drive_d = 1'b0;
              state_d = ST_MACK;
            end else begin
              drive_d = !tx_q[tx_bit];
              cnt_d   = cnt_q + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise_i) begin
            mack_d = !sda_s_i;
          end else if (scl_fall_i) begin
            if (mack_q) begin
              state_d = ST_TX;
              tx_d    = rd_data_i;
              addr_d  = addr_q + MEM_AW'(1);
              drive_d = !rd_data_i[7];
              cnt_d   = 4'd1;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: drive_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= PH_DEV;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      sh_q    <= '0;
      tx_q    <= '0;
      addr_q  <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      full_q  <= full_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      addr_q  <= addr_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      drive_q <= drive_d;
    end
  end

  assign addr_o        = addr_q;
  assign buf_idx_o     = addr_q[OFS_W-1:0];
  assign buf_data_o    = sh_q;
  assign commit_page_o = addr_q[MEM_AW-1:OFS_W];
  assign drive_low_o   = drive_q;
  assign idle_o        = (state_q == ST_IDLE);
  assign wr_phase_o    = (phase_q == PH_WD);
endmodule

// File: rtl/eeprom_slave.sv
module eeprom_slave #(
  parameter int PAGE_BYTES   = 64,
  parameter int PAGE_COUNT   = 32,
  parameter int WRITE_CYCLES = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_low_o,
  input  logic [1:0] strap_i,
  input  logic       wp_i
);
  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int MEM_AW = $clog2(PAGE_BYTES * PAGE_COUNT);
  localparam int PG_W   = MEM_AW - OFS_W;

  logic rst_n_sync, scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [MEM_AW-1:0] addr_ptr, mem_waddr;
  logic [7:0]        rd_data, mem_wdata, buf_data;
  logic [OFS_W-1:0]  buf_idx;
  logic [PG_W-1:0]   commit_page;
  logic buf_we, buf_clr, commit, busy, mem_we, fsm_idle, wr_phase;

  eeprom_bus_sync u_sync (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .scl_i        (scl_i),
    .sda_i        (sda_i),
    .rst_n_sync_o (rst_n_sync),
    .scl_s_o      (scl_s),
    .sda_s_o      (sda_s),
    .scl_rise_o   (scl_rise),
    .scl_fall_o   (scl_fall),
    .start_o      (start_det),
    .stop_o       (stop_det)
  );

  eeprom_fsm #(.OFS_W(OFS_W), .MEM_AW(MEM_AW)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_n_sync),
    .scl_rise_i    (scl_rise),
    .scl_fall_i    (scl_fall),
    .start_i       (start_det),
    .stop_i        (stop_det),
    .sda_s_i       (sda_s),
    .strap_i       (strap_i),
    .wp_i          (wp_i),
    .busy_i        (busy),
    .rd_data_i     (rd_data),
    .addr_o        (addr_ptr),
    .buf_we_o      (buf_we),
    .buf_idx_o     (buf_idx),
    .buf_data_o    (buf_data),
    .buf_clr_o     (buf_clr),
    .commit_o      (commit),
    .commit_page_o (commit_page),
    .drive_low_o   (sda_low_o),
    .idle_o        (fsm_idle),
    .wr_phase_o    (wr_phase)
  );

  eeprom_pagebuf #(.OFS_W(OFS_W), .PG_W(PG_W), .WRITE_CYCLES(WRITE_CYCLES)) u_pbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_sync),
    .we_i        (buf_we),
    .idx_i       (buf_idx),
    .data_i      (buf_data),
    .clr_i       (buf_clr),
    .commit_i    (commit),
    .page_i      (commit_page),
    .busy_o      (busy),
    .mem_we_o    (mem_we),
    .mem_waddr_o (mem_waddr),
    .mem_wdata_o (mem_wdata)
  );

  eeprom_array #(.MEM_AW(MEM_AW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .raddr_i (addr_ptr),
    .rdata_o (rd_data)
  );
endmodule

// File: rtl/eeprom_slave_chk.sv
module eeprom_slave_chk #(
  parameter int PG_W = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sda_low_o,
  input logic            scl_s,
  input logic            wp_i,
  input logic            busy,
  input logic            mem_we,
  input logic            fsm_idle,
  input logic            wr_phase,
  input logic [PG_W-1:0] page
);
  AST_DRIVE_ON_LOW_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_low_o) |-> !scl_s); // R2

  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsm_idle |-> !sda_low_o); // R2

  AST_PAGE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_phase && $past(wr_phase)) |-> $stable(page)); // R4

  AST_WRITE_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> busy); // R5

  AST_NO_ACK_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_low_o) |-> !busy); // R6

  AST_PROTECT_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !$past(wp_i)); // R7
endmodule

bind eeprom_slave eeprom_slave_chk #(.PG_W(PG_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sda_low_o (sda_low_o),
  .scl_s     (scl_s),
  .wp_i      (wp_i),
  .busy      (busy),
  .mem_we    (mem_we),
  .fsm_idle  (fsm_idle),
  .wr_phase  (wr_phase),
  .page      (commit_page)
);

// File: tb/sim_eeprom_slave.sv
`timescale 1ns/1ps
module sim_eeprom_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic wp = 1'b0;
  logic [1:0] strap = 2'b10;
  logic sda_low;
  wire  sda_bus = !(m_low || sda_low);

  int n_tests = 0;
  int n_fail  = 0;
  int viol    = 0;
  bit done    = 1'b0;

  logic [7:0] exp_q [$];
  logic [7:0] act_q [$];
  string      tag_q [$];

  localparam logic [7:0] SEL_W = 8'hA4;  // 1010 0 straps=10 write
  localparam logic [7:0] SEL_R = 8'hA5;

  always #4 clk = ~clk;  // 125 MHz

  eeprom_slave u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .scl_i     (scl),
    .sda_i     (sda_bus),
    .sda_low_o (sda_low),
    .strap_i   (strap),
    .wp_i      (wp)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_bit(input logic got, input logic expv, input string tag);
    n_tests++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, got, expv);
    end
  endtask

  task automatic bit_out(input logic b);
    tick(4); m_low = !b; tick(4); scl = 1'b1; tick(8); scl = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    tick(4); m_low = 1'b0; tick(4); scl = 1'b1; tick(4); b = sda_bus; tick(4); scl = 1'b0;
  endtask

  task automatic bus_start();
    tick(4); m_low = 1'b0; tick(4); scl = 1'b1; tick(4); m_low = 1'b1; tick(4); scl = 1'b0;
  endtask

  task automatic bus_stop();
    tick(4); m_low = 1'b1; tick(4); scl = 1'b1; tick(4); m_low = 1'b0; tick(4);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    ack = !b;
  endtask

  task automatic send_chk(input logic [7:0] d, input logic expv, input string tag);
    logic ack;
    send_byte(d, ack);
    chk_bit(ack, expv, tag);
  endtask

  task automatic recv_byte(input logic ack);
    logic [7:0] d;
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(!ack);
    act_q.push_back(d);
  endtask

  task automatic expect_byte(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // start, select, two address bytes, n data bytes, optional stop
  task automatic write_seq(input logic [15:0] a, input int n, input logic [7:0] d [4],
                           input bit do_stop, input string tag);
    bus_start();
    send_chk(SEL_W, 1'b1, tag);
    send_chk(a[15:8], 1'b1, tag);
    send_chk(a[7:0], 1'b1, tag);
    for (int i = 0; i < n; i++) send_chk(d[i], 1'b1, tag);
    if (do_stop) bus_stop();
  endtask

  task automatic read_at(input logic [15:0] a, input int n, input logic [7:0] d [4],
                         input string tag);
    for (int i = 0; i < n; i++) expect_byte(d[i], tag);
    bus_start();
    send_chk(SEL_W, 1'b1, tag);
    send_chk(a[15:8], 1'b1, tag);
    send_chk(a[7:0], 1'b1, tag);
    bus_start();
    send_chk(SEL_R, 1'b1, tag);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1);
    bus_stop();
  endtask

  task automatic read_cur(input int n, input logic [7:0] d [4], input string tag);
    for (int i = 0; i < n; i++) expect_byte(d[i], tag);
    bus_start();
    send_chk(SEL_R, 1'b1, tag);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1);
    bus_stop();
  endtask

  task automatic wait_window();
    tick(300);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0) begin
        logic [7:0] a, e;
        string t;
        a = act_q.pop_front();
        n_tests++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL unexpected read byte: got %h expected none", a);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (a !== e) begin
            n_fail++;
            $display("FAIL %s: read got %h expected %h", t, a, e);
          end
        end
      end
    end
  end

  // R2: the pull-low output may only move while the serial clock is low
  logic prev_low = 1'b0;
  always @(negedge clk) begin
    if (rst_n && (sda_low !== prev_low) && scl) viol++;
    prev_low <= sda_low;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d [4];
    tick(5);
    rst_n = 1'b1;
    tick(10);

    // R12: released line after reset, matching select acknowledged
    chk_bit(sda_low, 1'b0, "R12 line released");
    bus_start();
    send_chk(SEL_W, 1'b1, "R12 select ack");
    bus_stop();

    // R1: wrong strap bits -> no ack, following byte ignored until start
    bus_start();
    send_chk(8'hA2, 1'b0, "R1 mismatch nack");
    send_chk(SEL_W, 1'b0, "R1 ignored until start");
    bus_stop();
    bus_start();
    send_chk(8'h44, 1'b0, "R1 wrong code nack");
    bus_stop();

    // R3 byte write, R6 busy window
    d = '{8'h5A, 8'h00, 8'h00, 8'h00};
    write_seq(16'h0123, 1, d, 1'b1, "R3 byte write ack");
    bus_start();
    send_chk(SEL_W, 1'b0, "R6 nack in write window");
    bus_stop();
    wait_window();
    bus_start();
    send_chk(SEL_W, 1'b1, "R6 ack after window");
    bus_stop();
    d = '{8'h5A, 8'h00, 8'h00, 8'h00};
    read_at(16'h0123, 1, d, "R9 random read R3");

    // R4 page wrap; R8 current-address read; R10 pointer increment
    d = '{8'h99, 8'h00, 8'h00, 8'h00};
    write_seq(16'h0080, 1, d, 1'b1, "R4 neighbour write");
    wait_window();
    d = '{8'h11, 8'h22, 8'h33, 8'h44};
    write_seq(16'h007E, 4, d, 1'b1, "R4 page write ack");
    wait_window();
    d = '{8'h11, 8'h22, 8'h00, 8'h00};
    read_at(16'h007E, 2, d, "R4 page head R10");
    d = '{8'h99, 8'h00, 8'h00, 8'h00};
    read_cur(1, d, "R8 current read R4 untouched");
    d = '{8'h33, 8'h44, 8'h00, 8'h00};
    read_at(16'h0040, 2, d, "R4 wrapped bytes");

    // R10 wrap from last byte to 0
    d = '{8'hAA, 8'hBB, 8'h00, 8'h00};
    write_seq(16'h07FE, 2, d, 1'b1, "R10 setup");
    wait_window();
    d = '{8'hCC, 8'h00, 8'h00, 8'h00};
    write_seq(16'h0000, 1, d, 1'b1, "R10 setup");
    wait_window();
    d = '{8'hAA, 8'hBB, 8'hCC, 8'h00};
    read_at(16'h07FE, 3, d, "R10 sequential wrap");

    // R11 top address bit ignored
    d = '{8'h77, 8'h00, 8'h00, 8'h00};
    write_seq(16'h8010, 1, d, 1'b1, "R11 high bit write");
    wait_window();
    d = '{8'h77, 8'h00, 8'h00, 8'h00};
    read_at(16'h0010, 1, d, "R11 read back");

    // R5 repeated start before stop discards data
    d = '{8'h12, 8'h00, 8'h00, 8'h00};
    write_seq(16'h0010, 1, d, 1'b0, "R5 data ack");
    write_seq(16'h0020, 0, d, 1'b1, "R5 restart ack");
    wait_window();
    d = '{8'h77, 8'h00, 8'h00, 8'h00};
    read_at(16'h0010, 1, d, "R5 unchanged");

    // R7 write protect
    wp = 1'b1;
    d = '{8'h34, 8'h00, 8'h00, 8'h00};
    write_seq(16'h0010, 1, d, 1'b1, "R7 acks under protect");
    tick(8);
    wp = 1'b0;
    wait_window();
    d = '{8'h77, 8'h00, 8'h00, 8'h00};
    read_at(16'h0010, 1, d, "R7 array unchanged");

    tick(20);
    n_tests++;
    if (viol != 0) begin
      n_fail++;
      $display("FAIL R2 line moved with clock high: got %0d expected 0", viol);
    end
    n_tests++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule